// File: doc/BRIEF.md
# Byte ALU with Test Flag

This block is the arithmetic core of a small 8-bit processor. It computes eight-bit data results without any clock, and it keeps one registered test flag. The flag is the only state in the block. Comparison operations write the flag and leave the data result at zero, so a compare can never disturb a data register.

The flag can also be cleared by itself, or read back as a byte with the flag in bit 0. A second result path adds an 8-bit register value to a 16-bit special operand, such as an accumulator or a program-counter copy. The decoder around the block selects the operation and supplies the operands. It writes `data_out` or `spec_out` to its register file as the instruction requires.

Top module: `byte_alu_tflag`

## Requirements
- R1: For op_sel 0 (add) and op_sel 8 (add immediate), data_out = (opnd_a + opnd_b) mod 256. There is no carry output.
- R2: For op_sel 1 (subtract), data_out = (opnd_a - opnd_b) mod 256.
- R3: op_sel 2 shifts opnd_a left by one and fills bit 0 with 0. op_sel 3 shifts opnd_a right by one and fills bit 7 with 0. Neither shift keeps the sign bit.
- R4: op_sel 4 gives opnd_a AND opnd_b. op_sel 5 gives OR. op_sel 6 gives XOR. op_sel 7 gives the bitwise inverse of opnd_a.
- R5: op_sel 10 loads flag_q at the next rising clock edge with 1 if opnd_a > opnd_b as unsigned values, and 0 otherwise.
- R6: op_sel 11 loads flag_q at the next rising clock edge with 1 if opnd_a > opnd_b as two's-complement values, and 0 otherwise.
- R7: op_sel 12 loads flag_q at the next rising clock edge with 1 if opnd_a equals opnd_b, and 0 otherwise.
- R8: op_sel 9 clears flag_q to 0 at the next rising clock edge.
- R9: For op_sel 13, data_out = {7'b0, flag_q}.
- R10: For op_sel 14, spec_out = (spec_in + sign-extended opnd_b) mod 65536. For every other op_sel, spec_out = spec_in.
- R11: flag_we is 1 exactly for op_sel 9 to 12. flag_q keeps its value whenever flag_we is 0. data_out is 0 for op_sel 9 to 12, 14 and 15.
- R12: While rst_n is low, flag_q is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the test flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand (register value or r0) |
| opnd_b | input | 8 | Second operand or signed immediate |
| spec_in | input | 16 | Special register operand |
| data_out | output | 8 | Byte result |
| spec_out | output | 16 | Special add result |
| flag_we | output | 1 | High when the operation writes the flag |
| flag_q | output | 1 | Current test flag |

## Verification
Every data operation is run over all 65536 operand pairs. This separates wrap-around from saturation, and logical shifts from arithmetic shifts. The unsigned and signed compares are run with every opnd_a against a spread of opnd_b values that includes 0x7F, 0x80 and 0xFF. Values of opnd_a that straddle the sign boundary are what separate the signed compare from the unsigned one.

The special add is run with corner values of spec_in against every opnd_b. Positive and negative offsets show whether opnd_b is sign-extended and whether the carry out of bit 15 is dropped. Between flag writes, the flag is read back through the store-flag operation after unrelated operations, to show that it holds its value.

// File: rtl/byte_alu_tflag.sv
module byte_alu_tflag #(
  parameter int DW = 8,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [SW-1:0] spec_in,
  output logic [DW-1:0] data_out,
  output logic [SW-1:0] spec_out,
  output logic          flag_we,
  output logic          flag_q
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_SHL = 4'd2, OP_SHR = 4'd3,
                         OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_NOT = 4'd7,
                         OP_ADDI = 4'd8, OP_CLRF = 4'd9, OP_GTU = 4'd10, OP_GTS = 4'd11,
                         OP_EQ = 4'd12, OP_STF = 4'd13, OP_SADD = 4'd14;

  logic flag_d;

  always_comb begin
    data_out = '0;
    unique case (op_sel)
      OP_ADD, OP_ADDI: data_out = opnd_a + opnd_b;
      OP_SUB:          data_out = opnd_a - opnd_b;
      OP_SHL:          data_out = {opnd_a[DW-2:0], 1'b0};
      OP_SHR:          data_out = {1'b0, opnd_a[DW-1:1]};
      OP_AND:          data_out = opnd_a & opnd_b;
      OP_OR:           data_out = opnd_a | opnd_b;
      OP_XOR:          data_out = opnd_a ^ opnd_b;
      OP_NOT:          data_out = ~opnd_a;
      OP_STF:          data_out = {{(DW-1){1'b0}}, flag_q};
      default:         data_out = '0;
    endcase
  end

  always_comb begin
    flag_d = 1'b0;
    unique case (op_sel)
      OP_GTU:  flag_d = opnd_a > opnd_b;
      OP_GTS:  flag_d = $signed(opnd_a) > $signed(opnd_b);
      OP_EQ:   flag_d = opnd_a == opnd_b;
      default: flag_d = 1'b0;
    endcase
  end

  assign flag_we  = (op_sel >= OP_CLRF) && (op_sel <= OP_EQ);
  assign spec_out = (op_sel == OP_SADD) ? spec_in + {{(SW-DW){opnd_b[DW-1]}}, opnd_b} : spec_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_we) flag_q <= flag_d;
endmodule

module byte_alu_tflag_chk #(
  parameter int DW = 8,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_sel,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic [SW-1:0] spec_in,
  input logic [DW-1:0] data_out,
  input logic [SW-1:0] spec_out,
  input logic          flag_we,
  input logic          flag_q
);
  // R5
  gtu_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd10 |=> flag_q == ($past(opnd_a) > $past(opnd_b)));
  // R7
  eq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd12 |=> flag_q == ($past(opnd_a) == $past(opnd_b)));
  // R8
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd9 |=> !flag_q);
  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flag_q));
  // R11
  cmp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> data_out == '0);
  // R9
  stf_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd13 |-> data_out[DW-1:1] == '0 && data_out[0] == flag_q);
  // R3
  shr_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd3 |-> !data_out[DW-1]);
  // R10
  spec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel != 4'd14 |-> spec_out == spec_in);
endmodule

bind byte_alu_tflag byte_alu_tflag_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .spec_in(spec_in), .data_out(data_out), .spec_out(spec_out),
  .flag_we(flag_we), .flag_q(flag_q));

// File: tb/byte_alu_tflag_tb.sv
module byte_alu_tflag_tb;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  op_sel = 0;
  logic [7:0]  opnd_a = 0, opnd_b = 0;
  logic [15:0] spec_in = 0;
  logic [7:0]  data_out;
  logic [15:0] spec_out;
  logic        flag_we, flag_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byte_alu_tflag u_dut (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .spec_in(spec_in), .data_out(data_out), .spec_out(spec_out),
    .flag_we(flag_we), .flag_q(flag_q));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: op=%0d a=%0d b=%0d actual=%0d expected=%0d", req, op_sel, opnd_a, opnd_b, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int exp_data(input int op, input int a, input int b);
    case (op)
      0, 8: return (a + b) % 256;
      1: return (a - b + 256) % 256;
      2: return (a * 2) % 256;
      3: return a / 2;
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      7: return 255 - a;
      default: return 0;
    endcase
  endfunction

  task automatic flag_op(input int op, input int a, input int b);
    @(negedge clk);
    op_sel = 4'(op); opnd_a = 8'(a); opnd_b = 8'(b);
    @(posedge clk); #2;
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R12 reset flag", flag_q, 0);
    op_sel = 4'd10; opnd_a = 8'd9; opnd_b = 8'd1;
    @(posedge clk); #2;
    chk("R12 flag held in reset", flag_q, 0);
    @(negedge clk); op_sel = 0; rst_n = 1;

    for (int op = 0; op <= 8; op++) begin
      string tag;
      tag = (op == 0 || op == 8) ? "R1" : (op == 1) ? "R2" : (op <= 3) ? "R3" : "R4";
      op_sel = 4'(op);
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          opnd_a = 8'(a); opnd_b = 8'(b); #1;
          chk(tag, int'(data_out), exp_data(op, a, b));
        end
      chk("R11 no flag write on data op", int'(flag_we), 0);
    end

    for (int op = 10; op <= 12; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 19; k++) begin
          int b, e;
          b = (k < 16) ? k * 17 : (k == 16) ? 127 : (k == 17) ? 128 : a;
          flag_op(op, a, b);
          if (op == 10) begin e = int'(a > b); chk("R5 unsigned gt", int'(flag_q), e); end
          else if (op == 11) begin e = int'(sx(a) > sx(b)); chk("R6 signed gt", int'(flag_q), e); end
          else begin e = int'(a == b); chk("R7 equal", int'(flag_q), e); end
          chk("R11 compare data zero", int'(data_out), 0);
          chk("R11 compare strobe", int'(flag_we), 1);
        end

    flag_op(12, 5, 5);
    op_sel = 4'd13; #1;
    chk("R9 store flag one", int'(data_out), 1);
    for (int op = 0; op <= 8; op++) flag_op(op, 255, 3);
    flag_op(14, 255, 255);
    flag_op(15, 1, 1);
    chk("R11 data_out zero op15", int'(data_out), 0);
    op_sel = 4'd13; #1;
    chk("R11 flag held across non-flag ops", int'(data_out), 1);
    flag_op(9, 3, 1);
    chk("R8 clear flag", int'(flag_q), 0);
    op_sel = 4'd13; #1;
    chk("R9 store flag zero", int'(data_out), 0);

    for (int s = 0; s < 16; s++) begin
      int sv;
      sv = (s == 0) ? 0 : (s == 1) ? 65535 : (s == 2) ? 32767 : (s == 3) ? 32768 : (s * 4099) % 65536;
      spec_in = 16'(sv);
      op_sel = 4'd14;
      for (int b = 0; b < 256; b++) begin
        opnd_b = 8'(b); #1;
        chk("R10 special add", int'(spec_out), (sv + sx(b) + 65536) % 65536);
        chk("R11 special add data zero", int'(data_out), 0);
      end
      op_sel = 4'd0; #1;
      chk("R10 special pass", int'(spec_out), sv);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule